// File: doc/BRIEF.md
# Indexed-Port GPIO Controller with Edge Interrupts

This block gives a host eight general-purpose pins through a byte-wide port that has only two locations. The host writes a register number to the first location (the selector). It then reads or writes the chosen register through the second location (the window). Behind the window are these registers:

- a version byte;
- a control byte that switches the GPIO function and the interrupt output on and off;
- a sampled view of the pin levels;
- five per-pin bytes: output level, direction, tri-state override, interrupt enable and edge polarity.

Each pin input passes through a two-flop synchroniser. The synchronised value feeds both the input register and an edge detector. The edge detector sets a sticky pending flag for each pin. The interrupt line is the OR of the pending flags, gated by a control bit. The host clears a pending flag by writing a 1 to the matching bit of the input register.

Top module: `gpio_ix_top`

## Requirements
- R1: A host write to offset 0 loads the selector. A host read of offset 0 returns the last value written there. Accesses at offset 1 act on the register the selector names.
- R2: Selector 0x00 reads back the VERSION parameter (default 0x21). Writes to it are ignored.
- R3: Selector 0x9F is the control byte, reset value 0x81. Bit 0 enables the GPIO function and bit 3 enables the interrupt output. Bit 1 is read-only and reflects the `strap_in` input; a write to bit 1 has no effect. All other bits are stored as written.
- R4: The per-pin registers are read/write and use these selectors and reset values: output level 0xA1 (reset 0x00), direction 0xA4 (reset 0xF0, where 1 means output), tri-state 0xA5 (reset 0x00, where 1 means high impedance), interrupt enable 0xA6 (reset 0x00), and polarity 0xA7 (reset 0x00, where 0 means falling edge and 1 means rising edge).
- R5: `pin_oe[n]` is 1 only when control bit 0 is 1, direction bit n is 1 and tri-state bit n is 0.
- R6: Selector 0xA0 returns the pin levels two clock edges after they are applied on `pin_in`.
- R7: A pending flag is set when its pin shows the edge its polarity bit selects and the pin's interrupt enable is 1. The flag is set on the third clock edge after the pin changes. It stays set until it is cleared. A pin whose enable is 0 never sets its flag.
- R8: `irq` is high when any pending flag is set and control bit 3 is 1. It is low otherwise. Clearing bit 3 hides the flags but does not remove them.
- R9: Writing selector 0xA0 clears the pending flag of every bit written as 1. Bits written as 0 leave their flags unchanged.
- R10: A read of any selector not listed above returns 0x00. A write to it changes no register.
- R11: `pin_out` always equals the output-level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host access strobe |
| host_wr | input | 1 | Write when high, read when low |
| host_addr | input | 1 | 0 = selector, 1 = window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational |
| strap_in | input | 1 | Static strap reported in control bit 1 |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive levels |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so every read is sampled in the same cycle as the access. Register writes show up on `pin_oe` and `pin_out` one edge after the write. A pin change appears in the input register after two edges and raises `irq` after three. The bench checks `irq` after the second edge, where it must still be low, and again after the third, where it must be high. This catches a synchroniser stage that is added or missing.

// File: rtl/gpio_ix_pkg.sv
// Shared selector codes and widths for the indexed-port GPIO controller.
package gpio_ix_pkg;
    localparam int DW = 8;
    localparam logic [7:0] SEL_VER  = 8'h00;
    localparam logic [7:0] SEL_CTRL = 8'h9F;
    localparam logic [7:0] SEL_IN   = 8'hA0;
    localparam logic [7:0] SEL_OUT  = 8'hA1;
    localparam logic [7:0] SEL_DIR  = 8'hA4;
    localparam logic [7:0] SEL_TRI  = 8'hA5;
    localparam logic [7:0] SEL_IE   = 8'hA6;
    localparam logic [7:0] SEL_POL  = 8'hA7;
    localparam logic [7:0] CTRL_RST = 8'h81;
    localparam logic [7:0] DIR_RST  = 8'hF0;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_STRAP_BIT = 1;
    localparam int CTRL_IRQ_BIT  = 3;
endpackage

// File: rtl/gpio_ix_sync.sv
// Two-flop synchroniser, one chain per pin.
// Assumes pins are asynchronous to clk; reset clears both stages.
module gpio_ix_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_chain
            logic s1, s2;
            // Two-stage capture of one pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= async_in[g];
                    s2 <= s1;
                end
            end
            assign sync_out[g] = s2;
        end
    endgenerate
endmodule

// File: rtl/gpio_ix_irq.sv
// Per-pin edge detector with sticky pending flags.
// Assumes level_in is already synchronous. When a set and a clear reach
// the same pin in one cycle, the set wins.
module gpio_ix_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_in,
    input  logic [N-1:0] ie,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] hit;

    // Remember last synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_in;
    end

    // Select rising or falling edge per pin, masked by enable.
    always_comb begin
        for (int i = 0; i < N; i++)
            hit[i] = ie[i] & (pol[i] ? (level_in[i] & ~prev_q[i])
                                     : (~level_in[i] & prev_q[i]));
    end

    // Sticky flags: set on hit, clear on host request.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= hit | (pend & ~clr);
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R7: a flag only rises for an enabled pin.
            assert_rise_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[g]) |-> $past(ie[g]));
            // R9: a flag only drops after a clear request.
            assert_fall_needs_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend[g]) |-> $past(clr[g]));
        end
    endgenerate
endmodule

// File: rtl/gpio_ix_regs.sv
// Host port decode and register file behind the selector/window pair.
// Assumes one access per cycle, qualified by host_cs; reads are combinational.
module gpio_ix_regs
    import gpio_ix_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs,
    input  logic          host_wr,
    input  logic          host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          strap,
    input  logic [DW-1:0] pin_level,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] out_q,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] tri_q,
    output logic [DW-1:0] ie_q,
    output logic [DW-1:0] pol_q,
    output logic [DW-1:0] clr_mask
);
    logic [DW-1:0] sel_q;
    logic          wr_sel, wr_win;
    logic          mapped;

    assign wr_sel = host_cs & host_wr & ~host_addr;
    assign wr_win = host_cs & host_wr &  host_addr;

    // Selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= host_wdata;
    end

    // Writable registers, decoded by selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            out_q  <= '0;
            dir_q  <= DIR_RST;
            tri_q  <= '0;
            ie_q   <= '0;
            pol_q  <= '0;
        end else if (wr_win) begin
            case (sel_q)
                SEL_CTRL: ctrl_q <= host_wdata & ~(8'(1) << CTRL_STRAP_BIT);
                SEL_OUT:  out_q  <= host_wdata;
                SEL_DIR:  dir_q  <= host_wdata;
                SEL_TRI:  tri_q  <= host_wdata;
                SEL_IE:   ie_q   <= host_wdata;
                SEL_POL:  pol_q  <= host_wdata;
                default:  ;
            endcase
        end
    end

    // Clear pulses for pending flags.
    assign clr_mask = (wr_win && sel_q == SEL_IN) ? host_wdata : '0;

    // Read mux; unmapped selectors read zero.
    always_comb begin
        mapped = 1'b1;
        host_rdata = '0;
        if (!host_addr) host_rdata = sel_q;
        else begin
            case (sel_q)
                SEL_VER:  host_rdata = VERSION;
                SEL_CTRL: begin
                    host_rdata = ctrl_q;
                    host_rdata[CTRL_STRAP_BIT] = strap;
                end
                SEL_IN:   host_rdata = pin_level;
                SEL_OUT:  host_rdata = out_q;
                SEL_DIR:  host_rdata = dir_q;
                SEL_TRI:  host_rdata = tri_q;
                SEL_IE:   host_rdata = ie_q;
                SEL_POL:  host_rdata = pol_q;
                default:  mapped = 1'b0;
            endcase
        end
    end

    // R1: selector holds what was written.
    assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_sel) |-> sel_q == $past(host_wdata));
    // R10: writes through an unmapped selector change nothing.
    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_win && !mapped) |=> ($stable(ctrl_q) && $stable(out_q) && $stable(dir_q)
                                 && $stable(tri_q) && $stable(ie_q) && $stable(pol_q)));
    // R3: the strap bit is never stored.
    assert_strap_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_win && sel_q == SEL_CTRL) |-> !ctrl_q[CTRL_STRAP_BIT]);
endmodule

// File: rtl/gpio_ix_top.sv
// Indexed-port GPIO controller: register file, pin enables, synchroniser and
// edge interrupts. Assumes strap_in is static and pads are external.
module gpio_ix_top
    import gpio_ix_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs,
    input  logic          host_wr,
    input  logic          host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          strap_in,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    output logic          irq
);
    logic [DW-1:0] ctrl_q, out_q, dir_q, tri_q, ie_q, pol_q, clr_mask;
    logic [DW-1:0] level, pend;

    gpio_ix_regs #(.VERSION(VERSION)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .strap(strap_in), .pin_level(level),
        .ctrl_q(ctrl_q), .out_q(out_q), .dir_q(dir_q), .tri_q(tri_q),
        .ie_q(ie_q), .pol_q(pol_q), .clr_mask(clr_mask)
    );

    gpio_ix_sync #(.N(DW)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(level)
    );

    gpio_ix_irq #(.N(DW)) irq_i (
        .clk(clk), .rst_n(rst_n), .level_in(level), .ie(ie_q), .pol(pol_q),
        .clr(clr_mask), .pend(pend)
    );

    // Pin drive: enable, direction and no tri-state override.
    assign pin_out = out_q;
    assign pin_oe  = {DW{ctrl_q[CTRL_EN_BIT]}} & dir_q & ~tri_q;
    // Interrupt line: gated OR of pending flags.
    assign irq     = ctrl_q[CTRL_IRQ_BIT] & (|pend);

    // R8: the line is quiet whenever nothing is pending.
    assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);
endmodule

// File: tb/gpio_ix_top_tb_top.sv
module gpio_ix_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_wr = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       strap_in = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;
    int total = 0, bad = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    gpio_ix_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .strap_in(strap_in), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // {selector, write value, expected readback}
    localparam logic [23:0] TBL [9] = '{
        {8'hA1, 8'h5A, 8'h5A}, {8'hA4, 8'h3C, 8'h3C}, {8'hA5, 8'h0F, 8'h0F},
        {8'hA6, 8'h81, 8'h81}, {8'hA7, 8'hFF, 8'hFF}, {8'h00, 8'h12, 8'h21},
        {8'h9F, 8'hFF, 8'hFD}, {8'h33, 8'hAA, 8'h00}, {8'hFF, 8'h55, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hrd(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_cs = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] s, input logic [7:0] d);
        hwr(1'b0, s); hwr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] s, output logic [7:0] d);
        hwr(1'b0, s); hrd(1'b1, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: R3, R4, R5, R8, R11
        reg_rd(8'h9F, rv); chk("R3 ctrl reset", rv, 8'h81);
        strap_in = 1'b1;
        hrd(1'b1, rv); chk("R3 strap bit", rv, 8'h83);
        strap_in = 1'b0;
        reg_rd(8'hA4, rv); chk("R4 dir reset", rv, 8'hF0);
        reg_rd(8'hA7, rv); chk("R4 pol reset", rv, 8'h00);
        chk("R5 oe reset", pin_oe, 8'hF0);
        chk("R11 out reset", pin_out, 8'h00);
        chk("R8 irq reset", {7'b0, irq}, 8'h00);

        // Table of register write/readback cases: R1, R2, R3, R4, R10
        for (int i = 0; i < 9; i++) begin
            reg_wr(TBL[i][23:16], TBL[i][15:8]);
            hrd(1'b0, rv); chk("R1 selector readback", rv, TBL[i][23:16]);
            hrd(1'b1, rv); chk("R2/R3/R4/R10 window", rv, TBL[i][7:0]);
        end
        // R10: unmapped writes left every mapped register intact
        reg_rd(8'hA1, rv); chk("R10 out intact", rv, 8'h5A);
        reg_rd(8'hA7, rv); chk("R10 pol intact", rv, 8'hFF);
        chk("R11 pin_out", pin_out, 8'h5A);

        // R5: enable, direction, tri-state
        reg_wr(8'h9F, 8'h01); reg_wr(8'hA4, 8'hFF);
        chk("R5 oe masked by tri", pin_oe, 8'hF0);
        reg_wr(8'hA5, 8'h00); chk("R5 oe all", pin_oe, 8'hFF);
        reg_wr(8'h9F, 8'h00); chk("R5 oe disabled", pin_oe, 8'h00);

        // R6: input sampling latency
        hwr(1'b0, 8'hA0);
        @(negedge clk); pin_in = 8'h96;
        @(posedge clk); @(negedge clk);
        hrd(1'b1, rv); chk("R6 input level", rv, 8'h96);

        // R7/R8/R9: rising edge on pin 0
        pin_in = 8'h00;
        reg_wr(8'hA6, 8'h01); reg_wr(8'hA7, 8'h01); reg_wr(8'h9F, 8'h08);
        repeat (4) @(negedge clk);
        reg_wr(8'hA0, 8'hFF);
        chk("R9 cleared", {7'b0, irq}, 8'h00);
        @(negedge clk); pin_in = 8'h01;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 not yet", {7'b0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R7 rising set", {7'b0, irq}, 8'h01);
        reg_wr(8'h9F, 8'h00); chk("R8 gated off", {7'b0, irq}, 8'h00);
        reg_wr(8'h9F, 8'h08); chk("R8 sticky", {7'b0, irq}, 8'h01);
        reg_wr(8'hA0, 8'h02); chk("R9 other bit", {7'b0, irq}, 8'h01);
        reg_wr(8'hA0, 8'h01); chk("R9 own bit", {7'b0, irq}, 8'h00);

        // R7: falling edge selection
        reg_wr(8'hA7, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        repeat (3) @(posedge clk); #1;
        chk("R7 falling set", {7'b0, irq}, 8'h01);
        reg_wr(8'hA0, 8'hFF);

        // R7: disabled pin does not set
        @(negedge clk); pin_in = 8'h02;
        repeat (4) @(negedge clk); pin_in = 8'h00;
        repeat (4) @(negedge clk);
        chk("R7 disabled pin", {7'b0, irq}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule